// File: doc/BRIEF.md
# Adaptive Gate Interlock for a Synchronous Buck Half-Bridge

This block sits between a pulse-width-modulated control signal and the two gate commands of one synchronous buck leg. It closes the dead time by feedback and not by a fixed delay. When the PWM level changes, it first withdraws the gate that is on. It waits until a digitized sense flag shows that this switch has really turned off. Only then does it command the complementary gate on. A PWM input held at either level keeps one gate on for as long as it is held, so the duty ratio can reach both 0% and 100%.

A parameter selects which node proves that the high-side switch is off. In the source-only variant this is the switch (phase) node falling below threshold. In the sink/source variant it is the high-side gate itself. In both variants the low-side switch counts as off once its gate is below threshold. The sense flags come from external comparators and pass through a two-flop synchronizer before they are used. Deasserting the enable, a timeout while waiting for an off flag, or (sink/source variant only) a sleep request drives both gates low. A timeout also raises a fault, which stays set until the enable is deasserted.

Top module: `buck_gate_interlock`

## Requirements
- R1: The high-gate and low-gate commands are never high in the same cycle.
- R2: On a PWM rise, the low-gate command drops at the first clock edge. The high-gate command rises only after the synchronized low-side-off flag (`lg_low`) is seen, and it stays low while that flag is 0.
- R3: On a PWM fall, the high-gate command drops at the first clock edge. The low-gate command rises only after the synchronized high-side-off flag is seen.
- R4: With `SINK_SOURCE`=1 the high-side-off flag is `hg_low` and `phase_low` has no effect. With `SINK_SOURCE`=0 it is `phase_low` and `hg_low` has no effect.
- R5: With `SINK_SOURCE`=1, `sleep_req`=1 forces both gate commands low at the next edge. Once sleep is released, switching resumes. With `SINK_SOURCE`=0, `sleep_req` has no effect.
- R6: `enable`=0 forces both gate commands low at the next edge and clears the fault output.
- R7: PWM held at 1 keeps the high gate on indefinitely (100% duty), whatever the sense flags do. PWM held at 0 likewise keeps the low gate on (0% duty).
- R8: If an awaited off flag is still absent after `TIMEOUT_CYC` cycles of waiting, `fault` goes to 1 and both gates go low. Both stay that way until `enable` is deasserted.
- R9: During and right after reset, both gate commands and `fault` are 0.
- R10: A sense flag change reaches the gate commands three clock edges after it is applied: two synchronizer flops, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm | input | 1 | PWM control level: 1 requests high side, 0 requests low side |
| enable | input | 1 | 0 = shutdown, both gates off, fault cleared |
| sleep_req | input | 1 | Sleep request (acts only when SINK_SOURCE=1) |
| phase_low | input | 1 | Switch node below threshold (asynchronous) |
| hg_low | input | 1 | High-side gate below threshold (asynchronous) |
| lg_low | input | 1 | Low-side gate below threshold (asynchronous) |
| hg_cmd | output | 1 | High-side gate command |
| lg_cmd | output | 1 | Low-side gate command |
| fault | output | 1 | Off-flag timeout seen; sticky until enable low |

## Verification
A wrong interlock state shows up most dangerously as both gate commands high in one cycle. That would appear at the ports on the very edge it happened, so a monitor watches every cycle. A state that skips the wait for the off flag shows as a gate rising earlier than the three-edge synchronizer latency allows. A state that never leaves a wait shows as a gate stuck low, and then as a fault exactly `TIMEOUT_CYC` edges after the wait began. The bench drives both variants side by side with the same stimulus, so a wrong choice of sensed node shows as their outputs diverging.

// File: rtl/buck_gate_interlock.sv
module buck_gate_interlock #(
  parameter bit SINK_SOURCE = 1'b1,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm,
  input  logic enable,
  input  logic sleep_req,
  input  logic phase_low,
  input  logic hg_low,
  input  logic lg_low,
  output logic hg_cmd,
  output logic lg_cmd,
  output logic fault
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIM = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [2:0] {ST_OFF, ST_WLO, ST_HI, ST_WHI, ST_LO} st_t;

  st_t st, nxt;
  logic [1:0] sync1, sync2;
  logic [TW-1:0] tmr;
  logic trip, active, hi_off, lo_off, hi_raw, waiting;

  assign hi_raw = SINK_SOURCE ? hg_low : phase_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {hi_raw, lg_low};
      sync2 <= sync1;
    end

  assign hi_off  = sync2[1];
  assign lo_off  = sync2[0];
  assign active  = enable && !fault && !(SINK_SOURCE && sleep_req);
  assign waiting = (st == ST_WLO) || (st == ST_WHI);

  always_comb begin
    nxt  = st;
    trip = 1'b0;
    if (!active) nxt = ST_OFF;
    else begin
      case (st)
        ST_OFF: nxt = pwm ? ST_WLO : ST_WHI;
        ST_WLO:
          if (!pwm) nxt = ST_WHI;
          else if (lo_off) nxt = ST_HI;
          else if (tmr == LIM) begin
            nxt  = ST_OFF;
            trip = 1'b1;
          end
        ST_HI: if (!pwm) nxt = ST_WHI;
        ST_WHI:
          if (pwm) nxt = ST_WLO;
          else if (hi_off) nxt = ST_LO;
          else if (tmr == LIM) begin
            nxt  = ST_OFF;
            trip = 1'b1;
          end
        ST_LO: if (pwm) nxt = ST_WLO;
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_OFF;
    else st <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr <= '0;
    else if (nxt != st || !waiting) tmr <= '0;
    else tmr <= tmr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fault <= 1'b0;
    else if (!enable) fault <= 1'b0;
    else if (trip) fault <= 1'b1;

  assign hg_cmd = (st == ST_HI);
  assign lg_cmd = (st == ST_LO);

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hg_cmd && lg_cmd));

  // R2
  hg_after_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hg_cmd) |-> $past(lo_off));

  // R3
  lg_after_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lg_cmd) |-> $past(hi_off));

  // R6
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hg_cmd && !lg_cmd && !fault));

  // R8
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!hg_cmd && !lg_cmd));

  generate
    if (SINK_SOURCE) begin : g_sleep
      // R5
      sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (!hg_cmd && !lg_cmd));
    end
  endgenerate

endmodule

// File: tb/buck_gate_interlock_tb.sv
`timescale 1ns/1ps
module buck_gate_interlock_tb_top;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, enable = 1'b0, sleep_req = 1'b0;
  logic phase_low = 1'b0, hg_low = 1'b0, lg_low = 1'b0;
  logic ss_hg, ss_lg, ss_flt, so_hg, so_lg, so_flt;
  int checks = 0, errors = 0;
  bit overlap = 1'b0;

  always #4 clk = ~clk;

  buck_gate_interlock #(.SINK_SOURCE(1'b1), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .enable(enable), .sleep_req(sleep_req),
    .phase_low(phase_low), .hg_low(hg_low), .lg_low(lg_low),
    .hg_cmd(ss_hg), .lg_cmd(ss_lg), .fault(ss_flt));

  buck_gate_interlock #(.SINK_SOURCE(1'b0), .TIMEOUT_CYC(TO)) dut_src_i (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .enable(enable), .sleep_req(sleep_req),
    .phase_low(phase_low), .hg_low(hg_low), .lg_low(lg_low),
    .hg_cmd(so_hg), .lg_cmd(so_lg), .fault(so_flt));

  // {pwm, phase_low, hg_low, lg_low, ss_hg, ss_lg, so_hg, so_lg}
  localparam logic [7:0] VEC [11] = '{
    8'b0110_0101, 8'b1110_0000, 8'b1111_1010, 8'b1001_1010,
    8'b0001_0000, 8'b0101_0001, 8'b0011_0101, 8'b0000_0101,
    8'b1000_0000, 8'b0010_0100, 8'b0110_0101};

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n && ((ss_hg && ss_lg) || (so_hg && so_lg))) overlap = 1'b1;

  task automatic finish_run();
    chk("R1", "never both gates high", overlap, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R9", "ss hg in reset", ss_hg, 1'b0);
    chk("R9", "ss lg in reset", ss_lg, 1'b0);
    chk("R9", "fault in reset", ss_flt, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R9", "so lg after reset", so_lg, 1'b0);
    chk("R9", "so fault after reset", so_flt, 1'b0);
    enable = 1'b1;

    // R4 R7 R2 R3: vector walk, 4 cycles per step
    foreach (VEC[i]) begin
      {pwm, phase_low, hg_low, lg_low} = VEC[i][7:4];
      cyc(4);
      chk("R4/R2/R3/R7", $sformatf("step %0d ss hg", i), ss_hg, VEC[i][3]);
      chk("R4/R2/R3/R7", $sformatf("step %0d ss lg", i), ss_lg, VEC[i][2]);
      chk("R4/R2/R3/R7", $sformatf("step %0d so hg", i), so_hg, VEC[i][1]);
      chk("R4/R2/R3/R7", $sformatf("step %0d so lg", i), so_lg, VEC[i][0]);
    end

    // R2 R10: low gate drops first, high gate waits for synced flag
    pwm = 1'b1;
    cyc(1);
    chk("R2", "lg drops at first edge", ss_lg, 1'b0);
    chk("R2", "hg still low", ss_hg, 1'b0);
    lg_low = 1'b1;
    cyc(2);
    chk("R10", "hg low after 2 edges", ss_hg, 1'b0);
    cyc(1);
    chk("R10", "hg high after 3 edges", ss_hg, 1'b1);

    // R7: 100% duty held, flags irrelevant
    {phase_low, hg_low, lg_low} = 3'b000;
    cyc(40);
    chk("R7", "ss hg held", ss_hg, 1'b1);
    chk("R7", "so hg held", so_hg, 1'b1);

    // R8: timeout
    pwm = 1'b0;
    cyc(TO - 1);
    chk("R8", "no fault before limit", ss_flt, 1'b0);
    cyc(3);
    chk("R8", "fault after limit", ss_flt, 1'b1);
    chk("R8", "so fault after limit", so_flt, 1'b1);
    chk("R8", "hg off on fault", ss_hg, 1'b0);
    {phase_low, hg_low} = 2'b11;
    cyc(5);
    chk("R8", "lg held off in fault", ss_lg, 1'b0);
    chk("R8", "fault sticky", ss_flt, 1'b1);
    enable = 1'b0;
    cyc(1);
    chk("R6", "fault cleared by enable", ss_flt, 1'b0);

    // R6: enable low drops an active gate
    enable = 1'b1;
    cyc(4);
    chk("R6", "lg back after enable", ss_lg, 1'b1);
    pwm = 1'b1;
    lg_low = 1'b1;
    cyc(4);
    chk("R6", "hg on before disable", ss_hg, 1'b1);
    enable = 1'b0;
    cyc(1);
    chk("R6", "ss hg off", ss_hg, 1'b0);
    chk("R6", "so hg off", so_hg, 1'b0);

    // R5: sleep
    enable = 1'b1;
    pwm = 1'b0;
    lg_low = 1'b0;
    cyc(4);
    chk("R5", "ss lg before sleep", ss_lg, 1'b1);
    sleep_req = 1'b1;
    cyc(1);
    chk("R5", "ss lg off in sleep", ss_lg, 1'b0);
    chk("R5", "so lg ignores sleep", so_lg, 1'b1);
    cyc(5);
    chk("R5", "ss hg off in sleep", ss_hg, 1'b0);
    chk("R5", "ss lg still off", ss_lg, 1'b0);
    sleep_req = 1'b0;
    cyc(4);
    chk("R5", "ss lg resumes", ss_lg, 1'b1);

    finish_run();
  end
endmodule